// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a synchronous host issue single reads and writes to a 32K-word by 8-bit asynchronous static RAM. It drives the memory's address, its active-low select, write and output strobes, and an 8-bit data bus. The data bus is split into an output value, an output enable and an input value, so the pad ring can build the bidirectional pin. Every strobe window is a whole number of clock cycles. Each window is obtained by rounding up a nanosecond timing parameter divided by the clock period, so one parameter set retargets the block to another clock.

The host presents a request with a write flag, an address and write data. It is accepted on a clock edge where the controller is not busy. A read lowers select and output enable together with write enable held high. The input bus is captured once the slowest access path (address, select or output enable to data) has elapsed. The data comes back with a one-cycle valid pulse. A write keeps select and write enable low together for the longest of the pulse-width, address-setup and data-setup limits. Output enable stays high for the whole write. A short recovery phase then stretches the write to the minimum write cycle. After every read the strobes stay high for a float window, so the memory's drivers have turned off before this block can drive the bus.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and on the cycle after it, select, write enable and output enable are all high, the data driver is off, busy is low and the response valid is low.
- R2: A write holds write enable low for exactly N_WP consecutive cycles, with N_WP = ceil(max(50, 60, 30, 60 ns) / clock). That is 6 cycles at a 10 ns clock.
- R3: Write enable is low only while select is low. The value held on the data output while both are low is stored at the address of the accepted request.
- R4: Output enable stays high while write enable is low. The data driver is enabled in exactly the cycles where write enable is low.
- R5: An accepted write keeps busy high for exactly max(N_WP + 1, ceil(70 ns / clock)) cycles. That is 7 cycles at 10 ns.
- R6: A read holds select and output enable low with write enable high for exactly N_RD = ceil(max(70, 70, 35 ns) / clock) cycles. That is 7 cycles at 10 ns. The data captured is the input bus value in the last of those cycles.
- R7: Response valid pulses high for exactly one cycle, rising N_RD cycles after the edge that accepted the read, and carries the read data.
- R8: After a read all strobes stay high and busy stays high for N_TURN = ceil(25 ns / clock) cycles. That is 3 cycles at 10 ns. The data driver never turns on within N_TURN cycles of the memory's last driving cycle.
- R9: A request presented while busy is high is dropped: it is never performed, not even after busy falls.
- R10: While select is low the address bus holds the address of the request being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, taken when busy is low |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Transaction in progress; requests are ignored |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 15 | Memory address bus |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data driver |
| mem_dq_in | input | 8 | Data received from the memory |

## Verification
The hardest case to reach is a write that follows a read as closely as the host allows, since that is where driver overlap would occur. The bench sweeps 64 writes and then 64 reads back-to-back, and follows with tight read-write alternations at low and high addresses. Its memory model returns a garbage pattern until the read strobes have been held for the full access time, so a capture taken too early is caught. A monitor measures the gap between the memory's last driving cycle and the controller's driver turning on. The dropped-request case is forced by changing the address while holding the request high during a write.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_TURN,
        PH_WPULSE,
        PH_WREC
    } phase_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drv;
    } pins_t;

    localparam pins_t PINS_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned usub0(input int unsigned a, input int unsigned b);
        return (a > b) ? a - b : 0;
    endfunction

    function automatic pins_t pins_for(input phase_t ph);
        pins_t p;
        p = PINS_QUIET;
        case (ph)
            PH_READ: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
            end
            PH_WPULSE: begin
                p.ce_n = 1'b0;
                p.we_n = 1'b0;
                p.drv  = 1'b1;
            end
            default: p = PINS_QUIET;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
`timescale 1ns/1ps
module asram_phase_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned CW     = 4,
    parameter int unsigned N_RD   = 7,
    parameter int unsigned N_TURN = 3,
    parameter int unsigned N_WP   = 6,
    parameter int unsigned N_WREC = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go_rd,
    input  logic          go_wr,
    input  logic          tmr_done,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_len,
    output logic          capture,
    output logic          busy,
    output pins_t         pins
);
    phase_t ph_q, ph_d;
    pins_t  pins_q;

    always_comb begin
        ph_d     = ph_q;
        tmr_load = 1'b0;
        tmr_len  = CW'(1);
        capture  = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (go_wr) begin
                    ph_d     = PH_WPULSE;
                    tmr_load = 1'b1;
                    tmr_len  = CW'(N_WP);
                end else if (go_rd) begin
                    ph_d     = PH_READ;
                    tmr_load = 1'b1;
                    tmr_len  = CW'(N_RD);
                end
            end
            PH_READ: begin
                if (tmr_done) begin
                    ph_d     = PH_TURN;
                    tmr_load = 1'b1;
                    tmr_len  = CW'(N_TURN);
                    capture  = 1'b1;
                end
            end
            PH_WPULSE: begin
                if (tmr_done) begin
                    ph_d     = PH_WREC;
                    tmr_load = 1'b1;
                    tmr_len  = CW'(N_WREC);
                end
            end
            PH_TURN, PH_WREC: begin
                if (tmr_done) ph_d = PH_IDLE;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            pins_q <= PINS_QUIET;
        end else begin
            ph_q   <= ph_d;
            pins_q <= pins_for(ph_d);
        end
    end

    assign busy = (ph_q != PH_IDLE);
    assign pins = pins_q;
endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/1ps
module asram_dpath #(
    parameter int unsigned AW = 15,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] dout,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr  <= '0;
            dout      <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                mem_addr <= req_addr;
                dout     <= req_wdata;
            end
            rsp_valid <= capture;
            if (capture) rsp_rdata <= din;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned AW       = 15,
    parameter int unsigned DW       = 8,
    parameter int unsigned CLK_NS   = 10,
    parameter int unsigned T_RC_NS  = 70,
    parameter int unsigned T_AA_NS  = 70,
    parameter int unsigned T_ACE_NS = 70,
    parameter int unsigned T_DOE_NS = 35,
    parameter int unsigned T_HZ_NS  = 25,
    parameter int unsigned T_WC_NS  = 70,
    parameter int unsigned T_PWE_NS = 50,
    parameter int unsigned T_AW_NS  = 60,
    parameter int unsigned T_SCE_NS = 60,
    parameter int unsigned T_SD_NS  = 30
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int unsigned N_RD   = umax(1, umax(umax(ns_to_cyc(T_AA_NS, CLK_NS),
                                                       ns_to_cyc(T_ACE_NS, CLK_NS)),
                                                  ns_to_cyc(T_DOE_NS, CLK_NS)));
    localparam int unsigned N_TURN = umax(umax(1, ns_to_cyc(T_HZ_NS, CLK_NS)),
                                          usub0(ns_to_cyc(T_RC_NS, CLK_NS), N_RD));
    localparam int unsigned N_WP   = umax(1, umax(umax(ns_to_cyc(T_PWE_NS, CLK_NS),
                                                       ns_to_cyc(T_AW_NS, CLK_NS)),
                                                  umax(ns_to_cyc(T_SD_NS, CLK_NS),
                                                       ns_to_cyc(T_SCE_NS, CLK_NS))));
    localparam int unsigned N_WREC = umax(1, usub0(ns_to_cyc(T_WC_NS, CLK_NS), N_WP));
    localparam int unsigned N_MAX  = umax(umax(N_RD, N_TURN), umax(N_WP, N_WREC));
    localparam int unsigned CW     = $clog2(N_MAX + 1);

    logic          accept, go_rd, go_wr;
    logic          tmr_load, tmr_done, capture;
    logic [CW-1:0] tmr_len;
    pins_t         pins;

    assign accept = req && !busy;
    assign go_wr  = accept && req_wr;
    assign go_rd  = accept && !req_wr;

    asram_phase_timer #(.CW(CW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .len  (tmr_len),
        .done (tmr_done)
    );

    asram_seq #(
        .CW(CW), .N_RD(N_RD), .N_TURN(N_TURN), .N_WP(N_WP), .N_WREC(N_WREC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go_rd    (go_rd),
        .go_wr    (go_wr),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_len  (tmr_len),
        .capture  (capture),
        .busy     (busy),
        .pins     (pins)
    );

    asram_dpath #(.AW(AW), .DW(DW)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .din       (mem_dq_in),
        .mem_addr  (mem_addr),
        .dout      (mem_dq_out),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_ce_n  = pins.ce_n;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_dq_oe = pins.drv;
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
    parameter int unsigned AW = 15
) (
    input logic          clk,
    input logic          rst,
    input logic          req,
    input logic          busy,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_dq_oe
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !rsp_valid));

    a_r3_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce_n);

    a_r4_drive_in_write: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n));

    a_r6_read_we_high: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r8_driver_after_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    a_r9_take_when_idle: assert property (@(posedge clk) disable iff (rst)
        (req && !busy) |=> busy);

    a_r10_addr_held: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;
    localparam int CLK    = 10;
    localparam int N_RD   = (70 + CLK - 1) / CLK;
    localparam int N_TURN = (25 + CLK - 1) / CLK;
    localparam int N_WP   = (60 + CLK - 1) / CLK;
    localparam int N_WBSY = ((70 + CLK - 1) / CLK > N_WP + 1) ? (70 + CLK - 1) / CLK : N_WP + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int checks = 0;
    int failures = 0;

    logic [7:0]  ram     [256];
    logic [7:0]  exp_mem [256];
    logic [14:0] exp_addr = '0;
    int          wrun = 0, rrun = 0, rd_cnt = 0, gap = 1000;
    logic [14:0] w_a;
    logic [7:0]  w_d;
    logic        oe_prev = 1'b0;

    always #(CLK/2) clk = ~clk;

    asram_ctrl u0 (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    wire mem_drives = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq_in = (mem_drives && rd_cnt >= N_RD) ? ram[mem_addr[7:0]] : 8'hA5;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_we_n) check(!mem_ce_n, "R3 we low without ce", mem_ce_n, 0);
            if (!mem_we_n) check(mem_oe_n && mem_dq_oe, "R4 oe/driver in write",
                                 {mem_oe_n, mem_dq_oe}, 3);
            else if (mem_dq_oe) check(1'b0, "R4 driver outside write", 1, 0);
            if (!mem_ce_n) check(mem_addr == exp_addr, "R10 address", mem_addr, exp_addr);
            if (!mem_ce_n && !mem_we_n) begin
                wrun++;
                w_a = mem_addr;
                w_d = mem_dq_out;
            end else if (wrun != 0) begin
                check(wrun == N_WP, "R2 write pulse", wrun, N_WP);
                ram[w_a[7:0]] = w_d;
                wrun = 0;
            end
            if (mem_drives) rrun++;
            else if (rrun != 0) begin
                check(rrun == N_RD, "R6 read strobe", rrun, N_RD);
                rrun = 0;
            end
            if (mem_dq_oe && !oe_prev) check(gap >= N_TURN, "R8 float gap", gap, N_TURN);
            oe_prev = mem_dq_oe;
            gap     = mem_drives ? 0 : (gap < 1000 ? gap + 1 : gap);
            rd_cnt  = mem_drives ? rd_cnt + 1 : 0;
        end
    end

    task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        while (busy) @(negedge clk);
        req = 1'b1; req_wr = w; req_addr = a; req_wdata = d; exp_addr = a;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        int n;
        issue(1'b1, a, d);
        exp_mem[a[7:0]] = d;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check(n == N_WBSY, "R5 write busy", n, N_WBSY);
    endtask

    task automatic do_read(input logic [14:0] a);
        int lat, n;
        issue(1'b0, a, 8'h00);
        lat = 1;
        while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
        check(lat == N_RD + 1, "R7 valid latency", lat, N_RD + 1);
        check(rsp_rdata == exp_mem[a[7:0]], "R6 R7 read data", rsp_rdata, exp_mem[a[7:0]]);
        n = 0;
        while (busy) begin
            check(rsp_valid == (n == 0), "R7 single pulse", rsp_valid, n == 0);
            check(mem_ce_n && mem_oe_n && mem_we_n, "R8 quiet strobes", 0, 1);
            n++;
            @(negedge clk);
        end
        check(n == N_TURN, "R8 turnaround busy", n, N_TURN);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; exp_mem[i] = 8'h00; end
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !rsp_valid,
              "R1 during reset", 0, 1);
        rst = 1'b0;
        @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !rsp_valid,
              "R1 after reset", 0, 1);

        for (int a = 0; a < 64; a++) do_write(15'(a), 8'((a * 37 + 5) & 8'hFF));
        for (int a = 0; a < 64; a++) do_read(15'(a));

        // R9: hold request high with a new address while busy
        issue(1'b1, 15'd20, 8'h3C);
        exp_mem[20] = 8'h3C;
        req = 1'b1; req_wr = 1'b1; req_addr = 15'd21; req_wdata = 8'hEE;
        @(negedge clk);
        req = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) begin
            @(negedge clk);
            check(!busy && mem_ce_n, "R9 no late accept", busy, 0);
        end
        do_read(15'd21);
        do_read(15'd20);

        for (int k = 0; k < 16; k++) begin
            logic [14:0] a;
            a = (k % 2 == 0) ? 15'(15'h7F80 + k) : 15'(15'h4090 + k);
            do_write(a, 8'(8'hC3 ^ (k * 11)));
            do_read(a);
            do_read(15'(k));
        end
        do_write(15'h7FFF, 8'h5A);
        do_read(15'h7FFF);
        do_write(15'h0000, 8'hFF);
        do_read(15'h0000);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule